// File: doc/BRIEF.md
# Three-Wire Serial Register Port with Staged Commit

This block is the configuration port of a multi-channel converter. A host talks to it over three wires: a serial clock, an active-low chip select and a single data line. On chip the data line is split into an input, an output and an output enable, and the pad combines them. Every frame opens with a 16-bit command, followed by one or more 8-bit data bytes. The command sets the direction, how many bytes follow and the starting register address. All of the serial pins are sampled by the fast system clock through synchronizers, so the serial clock must run well below the system clock.

The datapath settings sit in a local group of registers, and each channel has its own copy of that group. A channel mask register chooses which copies a write reaches. One further register is shared by all channels. Every datapath register is double-buffered: a write changes only its staging copy. The staged values move into the active copies, which drive the outputs, only when the host sets the commit bit. The commit bit then clears itself.

The serial link has no back-pressure. A byte is accepted on its eighth serial clock rising edge. The host paces the frame with the serial clock, and it can pause between bytes by raising chip select.

Top module: `spx_regfile`

## Requirements
- R1: A frame begins on the first serial clock rising edge seen with chip select low after chip select has been high. The 16-bit command holds a read flag in bit 15 (1 = read), a length code in bits 14:13 (00 = one byte, 01 = two, 10 = three, 11 = stream until chip select rises) and the address in bits 12:0. Only addresses below 0x100 reach a register. Each byte written produces exactly one register write.
- R2: Bit 6 of register 0x00 selects bit order. When it is 0 (the reset value) every byte, the command included, is sent most-significant bit first. When it is 1, every byte is sent least-significant bit first, so the command goes out from bit 0 to bit 15. The order is fixed at the start of each frame.
- R3: After each data byte the address steps down by one in MSB-first frames and up by one in LSB-first frames.
- R4: A counted frame ends after its last byte. Any further serial clocks are ignored until chip select has been high. A streaming frame ends when chip select rises at a byte boundary.
- R5: In a counted frame, chip select high at a byte boundary pauses the frame, and the frame resumes when chip select falls again. Chip select high in the middle of a byte aborts the frame and discards that byte.
- R6: The data output enable is high only during the data phase of a read frame while chip select is low. It stays low during the command, during writes and while the frame is paused.
- R7: Read data changes on the serial clock falling edge and is stable at the following rising edge. The first data bit follows the falling edge after the 16th command bit.
- R8: Writes to 0x08..0x18 and to 0x30 go to staging copies, and reads of those addresses return the staging copy. The active outputs change only after a write of a value with bit 0 set to 0xFF. That bit clears itself, so 0xFF always reads 0.
- R9: Bits 1:0 of 0x05 form the channel mask (bit 0 = channel A, bit 1 = channel B), and both bits are set after reset. A write to 0x08..0x18 updates every channel whose mask bit is set. A read returns the lowest-numbered selected channel, and channel A when no bit is set.
- R10: Register 0x30 is common to all channels and ignores the channel mask.
- R11: After reset, 0x18 reads 0xC0 in both copies and every other register reads 0. Bits outside each register's field are stored as 0: 0x00 keeps bit 6, 0x05 keeps bits 1:0, 0xFF keeps bit 0. Addresses outside the map ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Chip select, active low |
| sdio_i | input | 1 | Data line as received from the pad |
| sdio_o | output | 1 | Data line value driven during reads |
| sdio_oe | output | 1 | Drive enable for the data line pad |
| act_loc | output | NCH*17*8 | Active local registers; channel c, register 0x08+i sits at bits (c*17+i)*8 +: 8 |
| act_glb | output | 8 | Active value of the common register 0x30 |

## Verification
The checker assumes that the serial clock stays in each level for several system clock cycles, so that every edge is seen and processed before the next one arrives. It also assumes that chip select and data change only while the serial clock is low. The stimulus drives every pin on the falling system clock edge and holds each serial clock phase for eight system clock cycles. It moves chip select only during the low phase, so the single-pulse write and the commit latency are measured on the timing the design expects.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef enum logic [1:0] {FS_IDLE, FS_INST, FS_DATA} frm_st_e;

  localparam logic [7:0] A_PORTCFG = 8'h00;
  localparam logic [7:0] A_CHSEL   = 8'h05;
  localparam logic [7:0] A_LOC_LO  = 8'h08;
  localparam logic [7:0] A_LOC_HI  = 8'h18;
  localparam logic [7:0] A_GBUF    = 8'h30;
  localparam logic [7:0] A_XFER    = 8'hFF;
  localparam logic [7:0] PORTCFG_MASK = 8'h40;
  localparam int         LSB_BIT   = 6;
  localparam logic [1:0] WL_STREAM = 2'b11;
  localparam int         LOC_COUNT = int'(A_LOC_HI - A_LOC_LO) + 1;

  function automatic logic [7:0] loc_rst(input logic [7:0] a);
    return (a == 8'h18) ? 8'hC0 : 8'h00;
  endfunction
endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spx_frame.sv
module spx_frame import spx_pkg::*; #(
  parameter int INST_W = 16,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              lsb_mode,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(INST_W);

  frm_st_e           st;
  logic [CNT_W-1:0]  bcnt;
  logic [INST_W-1:0] inst, inst_nx;
  logic [7:0]        rx, rx_nx;
  logic              rd_q, lsb_q, armed, sdo_q, wr_q;
  logic [1:0]        wlen_q, left_q;
  logic [ADDR_W-1:0] addr_q, wa_q;
  logic [7:0]        wd_q;
  logic              at_bound;

  always_comb begin
    inst_nx  = lsb_q ? {sdi_s, inst[INST_W-1:1]} : {inst[INST_W-2:0], sdi_s};
    rx_nx    = lsb_q ? {sdi_s, rx[7:1]} : {rx[6:0], sdi_s};
    at_bound = (bcnt == '0) || (st == FS_INST && bcnt == CNT_W'(INST_W/2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; bcnt <= '0; inst <= '0; rx <= '0;
      rd_q <= 1'b0; lsb_q <= 1'b0; armed <= 1'b0; sdo_q <= 1'b0; wr_q <= 1'b0;
      wlen_q <= '0; left_q <= '0; addr_q <= '0; wa_q <= '0; wd_q <= '0;
    end else begin
      wr_q <= 1'b0;
      case (st)
        FS_IDLE: begin
          if (csn_s) begin
            armed <= 1'b1;
          end else if (armed && sclk_rise) begin
            st    <= FS_INST;
            lsb_q <= lsb_mode;
            inst  <= lsb_mode ? {sdi_s, {(INST_W-1){1'b0}}} : {{(INST_W-1){1'b0}}, sdi_s};
            bcnt  <= CNT_W'(1);
          end
        end
        FS_INST: begin
          if (csn_s) begin
            if (!at_bound) begin st <= FS_IDLE; armed <= 1'b0; end
          end else if (sclk_rise) begin
            inst <= inst_nx;
            if (bcnt == CNT_W'(INST_W-1)) begin
              st     <= FS_DATA;
              bcnt   <= '0;
              rd_q   <= inst_nx[INST_W-1];
              wlen_q <= inst_nx[INST_W-2 -: 2];
              left_q <= inst_nx[INST_W-2 -: 2];
              addr_q <= inst_nx[ADDR_W-1:0];
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        FS_DATA: begin
          if (csn_s) begin
            if (!at_bound || wlen_q == WL_STREAM) begin st <= FS_IDLE; armed <= 1'b0; end
          end else begin
            if (sclk_fall && rd_q)
              sdo_q <= lsb_q ? rd_data[bcnt[2:0]] : rd_data[3'd7 - bcnt[2:0]];
            if (sclk_rise) begin
              rx <= rx_nx;
              if (bcnt == CNT_W'(7)) begin
                bcnt   <= '0;
                wr_q   <= !rd_q;
                wa_q   <= addr_q;
                wd_q   <= rx_nx;
                addr_q <= lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
                if (wlen_q != WL_STREAM) begin
                  if (left_q == '0) begin st <= FS_IDLE; armed <= 1'b0; end
                  else left_q <= left_q - 1'b1;
                end
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign rd_addr = addr_q;
  assign wr_en   = wr_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = (st == FS_DATA) && rd_q && !csn_s;
endmodule

// File: rtl/spx_regbank.sv
module spx_regbank import spx_pkg::*; #(
  parameter int NCH = 2,
  parameter int ADDR_W = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_data,
  output logic                       lsb_mode,
  output logic [NCH*LOC_COUNT*8-1:0] act_loc,
  output logic [7:0]                 act_glb
);
  localparam int SLOTS = NCH * LOC_COUNT;

  logic [7:0]       cfg_q, glb_sh, glb_act;
  logic [NCH-1:0]   chsel_q;
  logic             xfer_q;
  logic [SLOTS*8-1:0] sh_flat;
  logic             wpage, rpage;
  logic [7:0]       wa, ra;

  assign wpage = (wr_addr[ADDR_W-1:8] == '0);
  assign rpage = (rd_addr[ADDR_W-1:8] == '0);
  assign wa    = wr_addr[7:0];
  assign ra    = rd_addr[7:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar i = 0; i < LOC_COUNT; i++) begin : g_reg
      localparam logic [7:0] RA = A_LOC_LO + 8'(i);
      localparam logic [7:0] RV = loc_rst(RA);
      logic [7:0] sh_r, act_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_r  <= RV;
          act_r <= RV;
        end else begin
          if (wr_en && wpage && wa == RA && chsel_q[c]) sh_r <= wr_data;
          if (xfer_q) act_r <= sh_r;
        end
      end
      assign sh_flat[(c*LOC_COUNT+i)*8 +: 8] = sh_r;
      assign act_loc[(c*LOC_COUNT+i)*8 +: 8] = act_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      chsel_q <= '1;
      glb_sh  <= '0;
      glb_act <= '0;
      xfer_q  <= 1'b0;
    end else begin
      xfer_q <= wr_en && wpage && wa == A_XFER && wr_data[0];
      if (wr_en && wpage && wa == A_PORTCFG) cfg_q   <= wr_data & PORTCFG_MASK;
      if (wr_en && wpage && wa == A_CHSEL)   chsel_q <= wr_data[NCH-1:0];
      if (wr_en && wpage && wa == A_GBUF)    glb_sh  <= wr_data;
      if (xfer_q) glb_act <= glb_sh;
    end
  end

  always_comb begin
    int rch;
    int idx;
    rch = 0;
    for (int c = NCH - 1; c >= 0; c--) if (chsel_q[c]) rch = c;
    idx = rch * LOC_COUNT + int'(ra - A_LOC_LO);
    rd_data = '0;
    if (rpage) begin
      if (ra == A_PORTCFG)                     rd_data = cfg_q;
      else if (ra == A_CHSEL)                  rd_data = 8'(chsel_q);
      else if (ra == A_GBUF)                   rd_data = glb_sh;
      else if (ra == A_XFER)                   rd_data = {7'b0, xfer_q};
      else if (ra >= A_LOC_LO && ra <= A_LOC_HI) rd_data = sh_flat[idx*8 +: 8];
    end
  end

  assign lsb_mode = cfg_q[LSB_BIT];
  assign act_glb  = glb_act;
endmodule

// File: rtl/spx_regfile.sv
module spx_regfile import spx_pkg::*; #(
  parameter int NCH = 2,
  parameter int ADDR_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_csn,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe,
  output logic [NCH*LOC_COUNT*8-1:0] act_loc,
  output logic [7:0]                 act_glb
);
  logic              sclk_s, csn_s, sdi_s, sclk_prev;
  logic              sclk_rise, sclk_fall, lsb_mode;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;

  spx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_csn, sdio_i}),
    .q({sclk_s, csn_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;

  spx_frame #(.INST_W(16), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .csn_s(csn_s), .sdi_s(sdi_s), .lsb_mode(lsb_mode),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdio_o), .sdo_oe(sdio_oe)
  );

  spx_regbank #(.NCH(NCH), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lsb_mode(lsb_mode),
    .act_loc(act_loc), .act_glb(act_glb)
  );
endmodule

// File: rtl/spx_regfile_chk.sv
module spx_regfile_chk import spx_pkg::*; #(
  parameter int NCH = 2,
  parameter int ADDR_W = 13
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sclk_fall,
  input logic                       sdio_o,
  input logic                       sdio_oe,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [7:0]                 wr_data,
  input logic [NCH*LOC_COUNT*8-1:0] act_loc,
  input logic [7:0]                 act_glb
);
  logic xfer_wr;
  assign xfer_wr = wr_en && (wr_addr == ADDR_W'(A_XFER)) && wr_data[0];

  // R1: each accepted byte yields a single write strobe
  p_wr_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R6: a frame that drives the line never writes
  p_oe_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !wr_en);

  // R7: driven data only moves after a serial clock falling edge
  p_sdo_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && (sdio_o != $past(sdio_o))) |-> $past(sclk_fall));

  // R8: active copies move only two cycles after a commit write
  p_act_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_loc != $past(act_loc)) || (act_glb != $past(act_glb))) |-> $past(xfer_wr, 2));
endmodule

bind spx_regfile spx_regfile_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall),
  .sdio_o(sdio_o), .sdio_oe(sdio_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .act_loc(act_loc), .act_glb(act_glb)
);

// File: tb/sim_spx_regfile.sv
module sim_spx_regfile;
  localparam int NCH  = 2;
  localparam int NLOC = 17;
  localparam int HALF = 8;
  localparam int NVEC = 23;
  localparam logic [7:0] OPW = 8'h57;

  // {op, address, write data or expected read data}; R9 R10 R11 R8
  localparam logic [23:0] TAB [NVEC] = '{
    {8'h52, 8'h05, 8'h03}, {8'h57, 8'h0A, 8'h5A}, {8'h52, 8'h0A, 8'h5A},
    {8'h57, 8'h00, 8'hBF}, {8'h52, 8'h00, 8'h00}, {8'h57, 8'h05, 8'hFE},
    {8'h52, 8'h05, 8'h02}, {8'h57, 8'h0B, 8'h33}, {8'h57, 8'h05, 8'h01},
    {8'h52, 8'h0B, 8'h00}, {8'h57, 8'h05, 8'h02}, {8'h52, 8'h0B, 8'h33},
    {8'h57, 8'h05, 8'h00}, {8'h52, 8'h0B, 8'h00}, {8'h57, 8'h30, 8'h77},
    {8'h52, 8'h30, 8'h77}, {8'h52, 8'h18, 8'hC0}, {8'h57, 8'h07, 8'h12},
    {8'h52, 8'h07, 8'h00}, {8'h52, 8'hFF, 8'h00}, {8'h57, 8'h05, 8'h03},
    {8'h52, 8'h0A, 8'h5A}, {8'h52, 8'h05, 8'h03}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe;
  logic [NCH*NLOC*8-1:0] act_loc;
  logic [7:0] act_glb;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spx_regfile #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .act_loc(act_loc), .act_glb(act_glb)
  );

  function automatic logic [7:0] act_at(int c, int i);
    return act_loc[(c*NLOC+i)*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic d, output logic q, output logic o);
    sdio_i = d;
    wclk(HALF);
    q = sdio_o; o = sdio_oe;
    spi_sclk = 1'b1;
    wclk(HALF);
    spi_sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] b, input bit lsb, output logic [7:0] r, output bit oe_all);
    logic q, o;
    oe_all = 1'b1;
    for (int k = 0; k < 8; k++) begin
      int ix;
      ix = lsb ? k : 7 - k;
      xbit(b[ix], q, o);
      r[ix] = q;
      oe_all &= o;
    end
  endtask

  task automatic send_inst(input bit rd, input logic [1:0] wl, input logic [12:0] a,
                           input bit lsb, output bit oe_any);
    logic [15:0] w;
    logic q, o;
    w = {rd, wl, a};
    oe_any = 1'b0;
    for (int k = 0; k < 16; k++) begin
      xbit(w[lsb ? k : 15 - k], q, o);
      oe_any |= o;
    end
  endtask

  task automatic cs_low();
    spi_csn = 1'b0; wclk(HALF);
  endtask

  task automatic cs_high();
    wclk(HALF); spi_csn = 1'b1; wclk(4*HALF);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, input bit lsb);
    logic [7:0] r; bit oa, ob;
    cs_low(); send_inst(1'b0, 2'b00, {5'b0, a}, lsb, oa); xbyte(d, lsb, r, ob); cs_high();
  endtask

  task automatic rd1(input logic [7:0] a, input bit lsb, output logic [7:0] r);
    bit oa, ob;
    cs_low(); send_inst(1'b1, 2'b00, {5'b0, a}, lsb, oa); xbyte(8'h00, lsb, r, ob); cs_high();
    chk("R6 oe low in command", {7'b0, oa}, 8'h00);
    chk("R6 oe high in read data", {7'b0, ob}, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r, r2, r3, r4;
    bit oa, ob;
    wclk(5); rst_n = 1'b1; wclk(5);

    // R11 reset state at the ports
    chk("R11 reset ch A 0x18", act_at(0, 16), 8'hC0);
    chk("R11 reset ch B 0x18", act_at(1, 16), 8'hC0);
    chk("R11 reset ch A 0x08", act_at(0, 0), 8'h00);
    chk("R11 reset common", act_glb, 8'h00);
    chk("R6 oe low after reset", {7'b0, sdio_oe}, 8'h00);

    for (int n = 0; n < NVEC; n++) begin
      if (TAB[n][23:16] == OPW) wr1(TAB[n][15:8], TAB[n][7:0], 1'b0);
      else begin
        rd1(TAB[n][15:8], 1'b0, r);
        chk($sformatf("table step %0d R8 R9 R10 R11", n), r, TAB[n][7:0]);
      end
    end

    // R8 staged values stay off the outputs until commit
    chk("R8 ch A 0x0A before commit", act_at(0, 2), 8'h00);
    chk("R8 common before commit", act_glb, 8'h00);
    wr1(8'hFF, 8'h01, 1'b0);
    chk("R8 ch A 0x0A after commit", act_at(0, 2), 8'h5A);
    chk("R8 ch B 0x0A after commit", act_at(1, 2), 8'h5A);
    chk("R9 ch B 0x0B after commit", act_at(1, 3), 8'h33);
    chk("R9 ch A 0x0B after commit", act_at(0, 3), 8'h00);
    chk("R10 common after commit", act_glb, 8'h77);
    rd1(8'hFF, 1'b0, r);
    chk("R8 commit bit self clears", r, 8'h00);

    // R3 multi-byte write, address steps down
    cs_low(); send_inst(1'b0, 2'b10, 13'h012, 1'b0, oa);
    xbyte(8'h11, 1'b0, r, ob); xbyte(8'h22, 1'b0, r, ob); xbyte(8'h33, 1'b0, r, ob);
    cs_high();
    cs_low(); send_inst(1'b1, 2'b10, 13'h012, 1'b0, oa);
    xbyte(8'h00, 1'b0, r, ob); xbyte(8'h00, 1'b0, r2, ob); xbyte(8'h00, 1'b0, r3, ob);
    cs_high();
    chk("R3 R7 read 0x12", r, 8'h11);
    chk("R3 R7 read 0x11", r2, 8'h22);
    chk("R3 R7 read 0x10", r3, 8'h33);

    // R4 streaming read through four bytes
    cs_low(); send_inst(1'b1, 2'b11, 13'h012, 1'b0, oa);
    xbyte(8'h00, 1'b0, r, ob); xbyte(8'h00, 1'b0, r2, ob);
    xbyte(8'h00, 1'b0, r3, ob); xbyte(8'h00, 1'b0, r4, ob);
    cs_high();
    chk("R4 stream byte 0", r, 8'h11);
    chk("R4 stream byte 3", r4, 8'h00);
    chk("R4 oe low after stream end", {7'b0, sdio_oe}, 8'h00);

    // R4 counted frame ignores extra clocks
    cs_low(); send_inst(1'b0, 2'b00, 13'h014, 1'b0, oa);
    xbyte(8'h44, 1'b0, r, ob); xbyte(8'h55, 1'b0, r, ob);
    cs_high();
    rd1(8'h14, 1'b0, r);  chk("R4 counted byte kept", r, 8'h44);
    rd1(8'h13, 1'b0, r);  chk("R4 extra byte ignored", r, 8'h00);

    // R5 pause at a byte boundary
    cs_low(); send_inst(1'b0, 2'b01, 13'h016, 1'b0, oa);
    xbyte(8'hA1, 1'b0, r, ob);
    wclk(HALF); spi_csn = 1'b1; wclk(6*HALF); spi_csn = 1'b0; wclk(HALF);
    xbyte(8'hB2, 1'b0, r, ob);
    cs_high();
    cs_low(); send_inst(1'b1, 2'b01, 13'h016, 1'b0, oa);
    xbyte(8'h00, 1'b0, r, ob);
    wclk(HALF); spi_csn = 1'b1; wclk(6*HALF);
    chk("R6 oe low while paused", {7'b0, sdio_oe}, 8'h00);
    spi_csn = 1'b0; wclk(HALF);
    xbyte(8'h00, 1'b0, r2, ob);
    cs_high();
    chk("R5 first byte before pause", r, 8'hA1);
    chk("R5 byte after pause", r2, 8'hB2);

    // R5 abort in the middle of a byte
    cs_low(); send_inst(1'b0, 2'b00, 13'h017, 1'b0, oa);
    for (int k = 0; k < 4; k++) begin
      logic q, o;
      xbit(1'b1, q, o);
    end
    cs_high();
    rd1(8'h17, 1'b0, r);
    chk("R5 aborted byte discarded", r, 8'h00);

    // R2 R3 LSB-first order with rising address
    wr1(8'h00, 8'h40, 1'b0);
    cs_low(); send_inst(1'b0, 2'b01, 13'h009, 1'b1, oa);
    xbyte(8'h81, 1'b1, r, ob); xbyte(8'h42, 1'b1, r, ob);
    cs_high();
    cs_low(); send_inst(1'b1, 2'b01, 13'h009, 1'b1, oa);
    xbyte(8'h00, 1'b1, r, ob); xbyte(8'h00, 1'b1, r2, ob);
    cs_high();
    chk("R2 LSB-first read 0x09", r, 8'h81);
    chk("R3 LSB-first step up 0x0A", r2, 8'h42);
    rd1(8'h00, 1'b1, r);
    chk("R2 order bit readback", r, 8'h40);
    wr1(8'h00, 8'h00, 1'b1);
    rd1(8'h00, 1'b0, r);
    chk("R2 back to MSB-first", r, 8'h00);
    chk("R8 active 0x0A unchanged without commit", act_at(0, 2), 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule